// File: doc/BRIEF.md
# Retriggerable PWM Timer

This block is a counter-based pulse-width generator that starts only on demand. Once its enable is set, the counter parks at all-ones and waits. A trigger starts it. The trigger is either a selected edge on an external input or a one-cycle strobe from software. After the trigger, the counter runs from zero and repeats a period whose length and high time come from two compare values. A trigger that arrives while the counter is running restarts the period at once. This makes the block a retriggerable one-shot that keeps running as a continuous PWM source.

Compare writes go into holding registers. They reach the working buffers only when a period ends, or at any time while the counter is parked. A period therefore never sees a half-updated pair of values. A second output flips at the start of every period. Two one-cycle pulses mark the period end and the duty match. A count-clock enable gates the counting, so a prescaler outside the block sets the time base.

Top module: `trig_pwm_timer`

## Requirements
- R1: After reset, and on every clock while `run_en` is low, `cnt_val` is 0xFFFF and `pwm_out`, `tgl_out`, `per_irq` and `duty_irq` are all low.
- R2: While `run_en` is high and no trigger has occurred since it was set, `cnt_val` stays at 0xFFFF and `pwm_out` stays low, whatever `cnt_en` does.
- R3: A trigger is `sw_trig` high at a clock edge while `run_en` is high, or a selected edge of `ext_trig` while `run_en` is high. `edge_sel` encodes 2'b01 rising, 2'b10 falling, 2'b11 both and 2'b00 none. `ext_trig` passes through two synchronizer flops. A change that is set up before clock edge k therefore shows as `cnt_val` = 0 after edge k+2. A software strobe shows as `cnt_val` = 0 after the edge that samples it.
- R4: A trigger while the counter is running clears `cnt_val` to 0 at the next edge and restarts the period. It takes priority over a period wrap in the same cycle and does not reload the compare buffers.
- R5: While running, the counter advances by one on each clock with `cnt_en` high. On the advance after `cnt_val` equals the period buffer, it goes to 0 instead, and `per_irq` is high for exactly that one cycle. The period is (period value + 1) count ticks.
- R6: While running, `pwm_out` is high exactly when `cnt_val` is below the duty buffer. It is therefore high right after a trigger when the duty value is nonzero. It is always low for duty 0, and always high for a duty value above the period value.
- R7: `duty_irq` is high for one cycle each time the counter moves, by a tick or a trigger, onto a value equal to the duty buffer.
- R8: `tgl_out` inverts on every period wrap and on every trigger.
- R9: `per_wr` and `duty_wr` load holding registers. The working buffers copy the holding registers on every clock while the counter is not running, and at each period wrap. A write during a period does not change that period.
- R10: Dropping `run_en` while running returns `cnt_val` to 0xFFFF and drives all outputs low at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-clock enable, one tick per high cycle |
| run_en | input | 1 | Timer enable |
| edge_sel | input | 2 | External trigger edge select |
| ext_trig | input | 1 | Asynchronous external trigger input |
| sw_trig | input | 1 | Software trigger strobe |
| per_wr | input | 1 | Period holding register write |
| per_wdata | input | CNT_W | Period value |
| duty_wr | input | 1 | Duty holding register write |
| duty_wdata | input | CNT_W | Duty value |
| pwm_out | output | 1 | PWM waveform |
| tgl_out | output | 1 | Per-period toggle waveform |
| per_irq | output | 1 | Period-end pulse |
| duty_irq | output | 1 | Duty-match pulse |
| cnt_val | output | CNT_W | Counter readback |

## Verification
An error in the counter or the running flag shows on `cnt_val` in the same cycle, and shifts every later pulse. A buffer that reloads at the wrong time shows only one period later, as a wrong wrap point or a wrong `pwm_out` fall. For that reason the bench writes compare values mid-period and checks that the current period is unchanged. A wrong synchronizer depth or edge decode moves the restart by a cycle, or drops it. This shows at the third edge after an `ext_trig` change.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    function automatic logic edge_hit(input logic [1:0] sel, input logic cur, input logic prev);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        return (sel[0] & rise) | (sel[1] & fall);
    endfunction

endpackage

// File: rtl/tpwm_edge_det.sv
module tpwm_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_in,
    input  logic [1:0] edge_sel,
    output logic       hit
);
    import tpwm_pkg::*;

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_d, sync_q;
    logic         prev_d, prev_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_comb sync_d = {sync_q[TOP-1:0], trig_in};
        end else begin : g_single
            always_comb sync_d = trig_in;
        end
    endgenerate

    always_comb begin
        prev_d = sync_q[TOP];
        hit    = edge_hit(edge_sel, sync_q[TOP], prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/tpwm_hold.sv
module tpwm_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] val_d, val_q;

    always_comb val_d = wr ? wdata : val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign q = val_q;
endmodule

// File: rtl/tpwm_core.sv
module tpwm_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             run_en,
    input  logic             trig,
    input  logic [CNT_W-1:0] per_hold,
    input  logic [CNT_W-1:0] duty_hold,
    output logic [CNT_W-1:0] cnt,
    output logic             pwm,
    output logic             tgl,
    output logic             per_irq,
    output logic             duty_irq,
    output logic             running,
    output logic [CNT_W-1:0] per_buf,
    output logic [CNT_W-1:0] duty_buf
);
    localparam logic [CNT_W-1:0] PARK = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per_buf;
        logic [CNT_W-1:0] duty_buf;
        logic             running;
        logic             pwm;
        logic             tgl;
        logic             per_irq;
        logic             duty_irq;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     moved;

    always_comb begin
        st_d          = st_q;
        st_d.per_irq  = 1'b0;
        st_d.duty_irq = 1'b0;
        moved         = 1'b0;

        if (!st_q.running) begin
            st_d.per_buf  = per_hold;
            st_d.duty_buf = duty_hold;
        end

        if (!run_en) begin
            st_d.cnt     = PARK;
            st_d.running = 1'b0;
            st_d.tgl     = 1'b0;
        end else if (trig) begin
            st_d.cnt     = '0;
            st_d.running = 1'b1;
            st_d.tgl     = ~st_q.tgl;
            moved        = 1'b1;
        end else if (st_q.running && cnt_en) begin
            moved = 1'b1;
            if (st_q.cnt == st_q.per_buf) begin
                st_d.cnt      = '0;
                st_d.tgl      = ~st_q.tgl;
                st_d.per_irq  = 1'b1;
                st_d.per_buf  = per_hold;
                st_d.duty_buf = duty_hold;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        st_d.pwm      = st_d.running && (st_d.cnt < st_d.duty_buf);
        st_d.duty_irq = moved && st_d.running && (st_d.cnt == st_d.duty_buf);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cnt     <= PARK;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt      = st_q.cnt;
    assign pwm      = st_q.pwm;
    assign tgl      = st_q.tgl;
    assign per_irq  = st_q.per_irq;
    assign duty_irq = st_q.duty_irq;
    assign running  = st_q.running;
    assign per_buf  = st_q.per_buf;
    assign duty_buf = st_q.duty_buf;
endmodule

// File: rtl/trig_pwm_timer.sv
module trig_pwm_timer #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             run_en,
    input  logic [1:0]       edge_sel,
    input  logic             ext_trig,
    input  logic             sw_trig,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             duty_wr,
    input  logic [CNT_W-1:0] duty_wdata,
    output logic             pwm_out,
    output logic             tgl_out,
    output logic             per_irq,
    output logic             duty_irq,
    output logic [CNT_W-1:0] cnt_val
);
    logic             ext_hit;
    logic             trig;
    logic [CNT_W-1:0] per_hold, duty_hold;
    logic [CNT_W-1:0] per_buf, duty_buf;
    logic             run_q;

    tpwm_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (ext_trig),
        .edge_sel (edge_sel),
        .hit      (ext_hit)
    );

    tpwm_hold #(.W(CNT_W)) u_per_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (per_wr),
        .wdata (per_wdata),
        .q     (per_hold)
    );

    tpwm_hold #(.W(CNT_W)) u_duty_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (duty_wr),
        .wdata (duty_wdata),
        .q     (duty_hold)
    );

    assign trig = run_en & (sw_trig | ext_hit);

    tpwm_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .run_en    (run_en),
        .trig      (trig),
        .per_hold  (per_hold),
        .duty_hold (duty_hold),
        .cnt       (cnt_val),
        .pwm       (pwm_out),
        .tgl       (tgl_out),
        .per_irq   (per_irq),
        .duty_irq  (duty_irq),
        .running   (run_q),
        .per_buf   (per_buf),
        .duty_buf  (duty_buf)
    );
endmodule

// File: rtl/tpwm_checker.sv
module tpwm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             sw_trig,
    input logic             run_q,
    input logic [CNT_W-1:0] per_buf,
    input logic [CNT_W-1:0] duty_buf,
    input logic             pwm_out,
    input logic             tgl_out,
    input logic             per_irq,
    input logic             duty_irq,
    input logic [CNT_W-1:0] cnt_val
);
    localparam logic [CNT_W-1:0] PARK = '1;

    p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cnt_val == PARK && !pwm_out && !tgl_out && !per_irq && !duty_irq));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !run_q) |-> (cnt_val == PARK && !pwm_out));

    p_sw_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && sw_trig) |=> (cnt_val == '0 && run_q));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        per_irq |-> (cnt_val == '0 && $past(cnt_val) == $past(per_buf)));

    p_duty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && duty_buf == '0) |-> !pwm_out);

    p_duty_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        duty_irq |-> (run_q && cnt_val == duty_buf));

    p_buf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !per_irq) |-> ($stable(per_buf) && $stable(duty_buf)));
endmodule

bind trig_pwm_timer tpwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .sw_trig  (sw_trig),
    .run_q    (run_q),
    .per_buf  (per_buf),
    .duty_buf (duty_buf),
    .pwm_out  (pwm_out),
    .tgl_out  (tgl_out),
    .per_irq  (per_irq),
    .duty_irq (duty_irq),
    .cnt_val  (cnt_val)
);

// File: tb/sim_trig_pwm_timer.sv
module sim_trig_pwm_timer;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b1, run_en = 1'b0, ext_trig = 1'b0, sw_trig = 1'b0;
    logic [1:0]   edge_sel = 2'b00;
    logic         per_wr = 1'b0, duty_wr = 1'b0;
    logic [W-1:0] per_wdata = '0, duty_wdata = '0;
    logic         pwm_out, tgl_out, per_irq, duty_irq;
    logic [W-1:0] cnt_val;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_pwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .run_en(run_en),
        .edge_sel(edge_sel), .ext_trig(ext_trig), .sw_trig(sw_trig),
        .per_wr(per_wr), .per_wdata(per_wdata), .duty_wr(duty_wr),
        .duty_wdata(duty_wdata), .pwm_out(pwm_out), .tgl_out(tgl_out),
        .per_irq(per_irq), .duty_irq(duty_irq), .cnt_val(cnt_val)
    );

    // behavioural reference
    logic         m_s0, m_s1, m_prev;
    logic [W-1:0] m_ph, m_dh, m_pb, m_db, m_cnt;
    logic         m_run, m_pwm, m_tgl, m_pirq, m_dirq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_s0, m_s1, m_prev} = 3'b000;
            m_ph = '0; m_dh = '0; m_pb = '0; m_db = '0; m_cnt = 16'hFFFF;
            {m_run, m_pwm, m_tgl, m_pirq, m_dirq} = 5'b0;
        end else begin
            logic hit, trg, moved;
            logic [W-1:0] n_cnt, n_pb, n_db;
            logic n_run, n_tgl, n_pirq;
            hit = (edge_sel[0] && m_s1 && !m_prev) || (edge_sel[1] && !m_s1 && m_prev);
            trg = run_en && (sw_trig || hit);
            n_cnt = m_cnt; n_pb = m_pb; n_db = m_db; n_run = m_run; n_tgl = m_tgl;
            n_pirq = 1'b0; moved = 1'b0;
            if (!m_run) begin n_pb = m_ph; n_db = m_dh; end
            if (!run_en) begin
                n_cnt = 16'hFFFF; n_run = 1'b0; n_tgl = 1'b0;
            end else if (trg) begin
                n_cnt = 0; n_run = 1'b1; n_tgl = !m_tgl; moved = 1'b1;
            end else if (m_run && cnt_en) begin
                moved = 1'b1;
                if (m_cnt == m_pb) begin
                    n_cnt = 0; n_tgl = !m_tgl; n_pirq = 1'b1; n_pb = m_ph; n_db = m_dh;
                end else n_cnt = m_cnt + 16'd1;
            end
            m_cnt = n_cnt; m_pb = n_pb; m_db = n_db; m_run = n_run; m_tgl = n_tgl;
            m_pirq = n_pirq;
            m_pwm = n_run && (n_cnt < n_db);
            m_dirq = moved && n_run && (n_cnt == n_db);
            if (per_wr) m_ph = per_wdata;
            if (duty_wr) m_dh = duty_wdata;
            m_prev = m_s1; m_s1 = m_s0; m_s0 = ext_trig;
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 cnt_val", cnt_val, m_cnt);
            chk("R6 pwm_out", {15'd0, pwm_out}, {15'd0, m_pwm});
            chk("R8 tgl_out", {15'd0, tgl_out}, {15'd0, m_tgl});
            chk("R5 per_irq", {15'd0, per_irq}, {15'd0, m_pirq});
            chk("R7 duty_irq", {15'd0, duty_irq}, {15'd0, m_dirq});
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_per(input logic [W-1:0] v);
        @(negedge clk); per_wr = 1'b1; per_wdata = v;
        @(negedge clk); per_wr = 1'b0;
    endtask

    task automatic wr_duty(input logic [W-1:0] v);
        @(negedge clk); duty_wr = 1'b1; duty_wdata = v;
        @(negedge clk); duty_wr = 1'b0;
    endtask

    task automatic strobe;
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
    endtask

    task automatic wait_cnt(input logic [W-1:0] v);
        for (int i = 0; i < 400; i++) begin
            if (cnt_val == v) return;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1: reset / disabled state
        chk("R1 cnt after reset", cnt_val, 16'hFFFF);
        chk("R1 pwm after reset", {15'd0, pwm_out}, 16'd0);
        wr_per(16'd9);
        wr_duty(16'd3);
        // R2: enabled but waiting
        @(negedge clk); run_en = 1'b1;
        cyc(6);
        chk("R2 parked while waiting", cnt_val, 16'hFFFF);
        chk("R2 pwm low while waiting", {15'd0, pwm_out}, 16'd0);
        // R3: software trigger
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
        chk("R3 sw trigger clears", cnt_val, 16'd0);
        chk("R6 pwm high after trigger", {15'd0, pwm_out}, 16'd1);
        cyc(25);
        // R9: write mid-period must not change current period
        wait_cnt(16'd2);
        wr_per(16'd4);
        wait_cnt(16'd5);
        @(negedge clk);
        chk("R9 old period still active", cnt_val, 16'd6);
        wait_cnt(16'd0);
        wait_cnt(16'd4);
        @(negedge clk);
        chk("R9 new period after wrap", cnt_val, 16'd0);
        // R4: retrigger mid-period
        wait_cnt(16'd2);
        strobe();
        chk("R4 retrigger clears", cnt_val, 16'd0);
        // R3: external edges with sync latency
        wr_per(16'd40);
        cyc(50);
        edge_sel = 2'b01;
        wait_cnt(16'd20);
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R3 sync delay not yet", {15'd0, cnt_val == 16'd0}, 16'd0);
        @(negedge clk);
        chk("R3 rising edge restarts", cnt_val, 16'd0);
        edge_sel = 2'b00;
        wait_cnt(16'd10);
        @(negedge clk); ext_trig = 1'b0;
        cyc(3);
        chk("R3 sel 00 ignores edge", cnt_val, 16'd14);
        edge_sel = 2'b10;
        @(negedge clk); ext_trig = 1'b1;
        cyc(4);
        @(negedge clk); ext_trig = 1'b0;
        cyc(3);
        chk("R3 falling edge restarts", cnt_val, 16'd0);
        edge_sel = 2'b11;
        cyc(20);
        // R6 corner: duty 0 and duty above period
        wr_per(16'd7);
        wr_duty(16'd0);
        cyc(30);
        chk("R6 duty zero low", {15'd0, pwm_out}, 16'd0);
        wr_duty(16'd20);
        cyc(30);
        chk("R6 duty over period high", {15'd0, pwm_out}, 16'd1);
        // count enable gating
        wr_duty(16'd3);
        for (int i = 0; i < 120; i++) begin
            @(negedge clk); cnt_en = (i % 3 == 0);
        end
        cnt_en = 1'b1;
        // R10: disable while running
        @(negedge clk); run_en = 1'b0;
        @(negedge clk);
        chk("R10 disable parks counter", cnt_val, 16'hFFFF);
        chk("R10 disable drops tgl", {15'd0, tgl_out}, 16'd0);
        @(negedge clk); run_en = 1'b1; sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
        // mixed stimulus compared against the reference each clock
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            cnt_en   = ($urandom_range(0, 3) != 0);
            sw_trig  = ($urandom_range(0, 60) == 0);
            ext_trig = ($urandom_range(0, 25) == 0) ? ~ext_trig : ext_trig;
            edge_sel = (i % 500 == 0) ? 2'($urandom_range(0, 3)) : edge_sel;
            run_en   = ($urandom_range(0, 400) != 0);
            per_wr   = ($urandom_range(0, 30) == 0);
            per_wdata = 16'($urandom_range(0, 12));
            duty_wr  = ($urandom_range(0, 30) == 0);
            duty_wdata = 16'($urandom_range(0, 14));
        end
        {sw_trig, per_wr, duty_wr} = 3'b000;
        cyc(4);
        finish_run();
    end
endmodule